// File: doc/BRIEF.md
# Twin "1-then-0" Sequence Recognisers

This block watches a one-bit serial stream, taking one bit per rising clock edge, and flags every place where a 1 is followed directly by a 0. Two recognisers run on the same input at the same time.

The first is a state-only (Moore) machine with three states, so its flag is registered. The second is an input-aware (Mealy) machine with two states, so its flag is combinational in the input and appears one cycle earlier. Both present states are brought out, which lets a checker or a waveform compare the two machines and see that one-cycle gap. A build-time parameter sets the state encoding to either dense binary or one-hot. The reset is asserted asynchronously. It is released through a two-stage synchroniser, and the state registers stay in the idle state until the released reset has passed through both stages.

Top module: `pattern10_pair`

## Requirements
- R1: While `arst` is high, both state outputs hold their idle code and both flags are 0 whatever `din` is. Raising `arst` between clock edges forces the idle codes at once, with no clock edge needed.
- R2: After `arst` falls, the first two rising edges leave both machines in idle. The third rising edge is the first one that samples `din`.
- R3: Moore states are idle (nothing seen), one (a 1 seen) and onezero ("1,0" seen). With input 1, every state moves to one. With input 0, one moves to onezero, and idle and onezero both move to idle.
- R4: `moore_hit` is 1 only while the Moore machine is in onezero, and it does not depend on the current `din`. It therefore rises one clock after the completing 0 is applied.
- R5: Mealy states are idle and one. With input 1, both states move to one. With input 0, both states move to idle.
- R6: `mealy_hit` is 1 exactly when the Mealy machine is in one and `din` is 0 in the same cycle. It rises in the cycle in which the completing 0 is applied.
- R7: For the input run 0,1,0,0,0 starting from idle, the Moore states are idle, one, onezero, idle, idle and the Mealy states are idle, one, idle, idle, idle, one entry per cycle.
- R8: With `ONE_HOT`=0, the Moore codes are idle=2'b00, one=2'b01 and onezero=2'b10, and the Mealy codes are idle=1'b0 and one=1'b1.
- R9: With `ONE_HOT`=1, exactly one bit is set, and idle sits on the most significant bit. The Moore codes are idle=3'b100, one=3'b010 and onezero=3'b001, and the Mealy codes are idle=2'b10 and one=2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst | input | 1 | Asynchronous reset, active high |
| din | input | 1 | Serial input bit |
| moore_hit | output | 1 | Registered-state detect flag |
| mealy_hit | output | 1 | Input-aware detect flag |
| moore_state | output | 2 (binary) / 3 (one-hot) | Moore present-state code |
| mealy_state | output | 1 (binary) / 2 (one-hot) | Mealy present-state code |

## Verification
The bench runs a binary instance and a one-hot instance side by side. Both flags and both state codes are checked every cycle against a reference model, over the fixed 0,1,0,0,0 run and over a long random stream. Two design errors would show up here: a Mealy flag that waited for the clock, and a Moore flag that followed `din`; either would make the two flags line up instead of one trailing the other by a cycle. A Moore machine that fell back to idle from "1,0" on input 1, instead of moving to one, would miss the overlapping pattern in "1,0,1,0". The bench also raises reset between clock edges to catch a reset that is only synchronous. It counts the edges after release to catch a reset that skips the synchroniser or a release that takes too long.

// File: rtl/pattern10_pair.sv
`timescale 1ns/1ps
module pattern10_pair #(
  parameter bit ONE_HOT = 1'b0,
  localparam int MW = ONE_HOT ? 3 : 2,
  localparam int LW = ONE_HOT ? 2 : 1
) (
  input  logic          clk,
  input  logic          arst,
  input  logic          din,
  output logic          moore_hit,
  output logic          mealy_hit,
  output logic [MW-1:0] moore_state,
  output logic [LW-1:0] mealy_state
);

  localparam logic [MW-1:0] MO_IDLE = ONE_HOT ? MW'(4) : MW'(0);
  localparam logic [MW-1:0] MO_ONE  = ONE_HOT ? MW'(2) : MW'(1);
  localparam logic [MW-1:0] MO_OZ   = ONE_HOT ? MW'(1) : MW'(2);
  localparam logic [LW-1:0] ME_IDLE = ONE_HOT ? LW'(2) : LW'(0);
  localparam logic [LW-1:0] ME_ONE  = LW'(1);

  logic [1:0]    rel_q;
  logic          run;
  logic [MW-1:0] mo_q, mo_d;
  logic [LW-1:0] me_q, me_d;

  always_ff @(posedge clk or posedge arst)
    if (arst) rel_q <= 2'b00;
    else      rel_q <= {rel_q[0], 1'b1};

  assign run = rel_q[1];

  always_comb begin
    case (mo_q)
      MO_IDLE: mo_d = din ? MO_ONE : MO_IDLE;
      MO_ONE:  mo_d = din ? MO_ONE : MO_OZ;
      MO_OZ:   mo_d = din ? MO_ONE : MO_IDLE;
      default: mo_d = MO_IDLE;
    endcase
    case (me_q)
      ME_IDLE, ME_ONE: me_d = din ? ME_ONE : ME_IDLE;
      default:         me_d = ME_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge arst)
    if (arst) begin
      mo_q <= MO_IDLE;
      me_q <= ME_IDLE;
    end else if (!run) begin
      mo_q <= MO_IDLE;
      me_q <= ME_IDLE;
    end else begin
      mo_q <= mo_d;
      me_q <= me_d;
    end

  assign moore_hit   = (mo_q == MO_OZ);
  assign mealy_hit   = (me_q == ME_ONE) && !din;
  assign moore_state = mo_q;
  assign mealy_state = me_q;

  assert_release_hold_R2: assert property (@(posedge clk) disable iff (arst)
    !run |=> (mo_q == MO_IDLE && me_q == ME_IDLE));

  assert_oz_entry_R3: assert property (@(posedge clk) disable iff (arst)
    (mo_q == MO_OZ) |-> $past(mo_q == MO_ONE && !din));

  assert_moore_lags_mealy_R4: assert property (@(posedge clk) disable iff (arst)
    moore_hit |-> $past(mealy_hit));

  assert_mealy_return_R5: assert property (@(posedge clk) disable iff (arst)
    mealy_hit |=> (me_q == ME_IDLE));

  assert_mealy_after_one_R6: assert property (@(posedge clk) disable iff (arst)
    (me_q == ME_ONE) |-> $past(din));

  generate
    if (ONE_HOT) begin : g_oh_chk
      assert_single_bit_R9: assert property (@(posedge clk) disable iff (arst)
        ($countones(mo_q) == 1 && $countones(me_q) == 1));
    end
  endgenerate

endmodule

// File: tb/test_pattern10_pair.sv
`timescale 1ns/1ps
module test_pattern10_pair;

  logic clk = 1'b0, arst = 1'b1, din = 1'b0;
  logic mo_hit_b, me_hit_b, mo_hit_o, me_hit_o;
  logic [1:0] mo_st_b;
  logic [0:0] me_st_b;
  logic [2:0] mo_st_o;
  logic [1:0] me_st_o;

  always #2 clk = ~clk;

  pattern10_pair #(.ONE_HOT(1'b0)) i_pattern10_pair (
    .clk(clk), .arst(arst), .din(din), .moore_hit(mo_hit_b), .mealy_hit(me_hit_b),
    .moore_state(mo_st_b), .mealy_state(me_st_b));

  pattern10_pair #(.ONE_HOT(1'b1)) i_pattern10_pair_oh (
    .clk(clk), .arst(arst), .din(din), .moore_hit(mo_hit_o), .mealy_hit(me_hit_o),
    .moore_state(mo_st_o), .mealy_state(me_st_o));

  typedef struct { bit mo_f; bit me_f; int mo_s; int me_s; string tag; } item_t;
  item_t q[$];
  int ref_mo = 0, ref_me = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [1:0] mo_bin(int s); return (s == 0) ? 2'b00 : (s == 1) ? 2'b01 : 2'b10; endfunction
  function automatic logic [2:0] mo_oh(int s);  return (s == 0) ? 3'b100 : (s == 1) ? 3'b010 : 3'b001; endfunction
  function automatic logic [1:0] me_oh(int s);  return (s == 0) ? 2'b10 : 2'b01; endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag, bit mf, bit lf, int ms, int ls);
    check({tag, " R4 moore_hit bin"}, {3'b0, mo_hit_b}, {3'b0, mf});
    check({tag, " R4 moore_hit oh"},  {3'b0, mo_hit_o}, {3'b0, mf});
    check({tag, " R6 mealy_hit bin"}, {3'b0, me_hit_b}, {3'b0, lf});
    check({tag, " R6 mealy_hit oh"},  {3'b0, me_hit_o}, {3'b0, lf});
    check({tag, " R3 R8 moore_state bin"}, {2'b0, mo_st_b}, {2'b0, mo_bin(ms)});
    check({tag, " R3 R9 moore_state oh"},  {1'b0, mo_st_o}, {1'b0, mo_oh(ms)});
    check({tag, " R5 R8 mealy_state bin"}, {3'b0, me_st_b}, {3'b0, 1'(ls)});
    check({tag, " R5 R9 mealy_state oh"},  {2'b0, me_st_o}, {2'b0, me_oh(ls)});
  endtask

  task automatic drive(bit b, string tag);
    item_t it;
    @(negedge clk);
    din = b;
    it.mo_f = (ref_mo == 2);
    it.me_f = (ref_me == 1) && !b;
    it.mo_s = ref_mo;
    it.me_s = ref_me;
    it.tag  = tag;
    q.push_back(it);
    ref_mo = b ? 1 : ((ref_mo == 1) ? 2 : 0);
    ref_me = b ? 1 : 0;
  endtask

  always begin
    @(negedge clk);
    #1;
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      check_all(it.tag, it.mo_f, it.me_f, it.mo_s, it.me_s);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with din low and high
    repeat (3) @(negedge clk);
    #1 check_all("R1 din0", 0, 0, 0, 0);
    din = 1'b1;
    #0.5 check_all("R1 din1", 0, 0, 0, 0);
    // R2: release with din=1, two edges in idle, third samples
    @(negedge clk);
    arst = 1'b0;
    repeat (2) @(negedge clk);
    #1 check_all("R2 held", 0, 0, 0, 0);
    @(negedge clk);
    #1 check_all("R2 first", 0, 0, 1, 1);
    ref_mo = 1; ref_me = 1;
    // overlap "1,0,1,0" then return to idle
    drive(0, "R3"); drive(1, "R3"); drive(0, "R3"); drive(0, "R3");
    // R7 fixed run
    drive(0, "R7"); drive(1, "R7"); drive(0, "R7"); drive(0, "R7"); drive(0, "R7");
    for (int i = 0; i < 400; i++) drive(1'($urandom_range(0, 1)), "rand");
    // R1: asynchronous assertion between edges, from state one
    drive(1, "R1 pre");
    @(posedge clk);
    #0.5 arst = 1'b1;
    #0.5 check_all("R1 async", 0, 0, 0, 0);
    ref_mo = 0; ref_me = 0;
    @(negedge clk);
    din = 1'b0;
    arst = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 400; i++) drive(1'($urandom_range(0, 1)), "rand2");
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule